// File: doc/BRIEF.md
# Synchronous Serial Master with Frame FIFOs

This block is a memory-mapped serial master. Software sets up a frame format (a width from 4 to 16 bits, the idle level of the serial clock and the edge used for sampling), a bit-rate divider pair and a control word. It then writes frames into an eight-entry transmit queue through a data register. As long as the port is enabled and the transmit queue holds data, the engine takes one frame, pulls the active-low frame select low, shifts the frame out MSB first and shifts a reply in at the same time. When the frame is done it releases the select and pushes the received word into an eight-entry receive queue. Software reads received words from the same data address.

A status register shows the queue levels and activity. Three raw event flags (receive queue at least half full, transmit queue at most half full, receive overrun) are masked by enable bits and combined onto one interrupt line. A loopback mode sends the serial output straight back into the receive shifter, so the block can be tested without a partner device.

Top module: `spi_fifo_master`

## Requirements
- R1: After reset, frame select is high, the serial clock is low, the interrupt line is low, status reads 0x03 and the event register reads 0x02.
- R2: Byte offsets are: format 0x00, control 0x04, data 0x08, status 0x0C, rate prescale 0x10, events/clear 0x14. The format, control (bits 6:0) and prescale (bits 7:0) registers read back what was written.
- R3: Format bits 3:0 hold the frame width minus one, and a code below 3 selects 4 bits. Each frame has exactly that many clock periods. The low bits of the written word go out MSB first.
- R4: Format bit 6 sets the idle level of the serial clock. With format bit 7 clear, data is sampled on the leading edge of each clock period; with it set, data is sampled on the trailing edge.
- R5: Each serial clock half period lasts (P div 2)*(S+1) system clocks, where P is the prescale value and S is format bits 15:8. A P below 2 acts as 2.
- R6: With control bit 3 set, the receive shifter takes the serial output and ignores the external input. With it clear, the external input is received. Received words are right-justified and zero-extended.
- R7: Each queue holds 8 frames. A data write while the transmit queue is full is dropped. Status bits are: 0 transmit empty, 1 transmit not full, 2 receive not empty, 3 receive full, 4 busy.
- R8: A frame that completes while the receive queue is full is discarded and sets the overrun flag (event bit 2). A write of any value to 0x14 clears the flag.
- R9: Event bit 0 is high when the receive queue holds 4 or more frames, and event bit 1 is high when the transmit queue holds 4 or fewer. The interrupt line is the OR of each event bit ANDed with control bit 0, 1 or 2 respectively.
- R10: While control bit 4 (enable) is clear, no frame starts, frame select stays high and queued data waits.
- R11: Busy is high while a frame is shifting or the transmit queue is not empty.
- R12: A read of 0x08 pops one received word. When the receive queue is empty, it returns 0 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (pops receive data at 0x08) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr |
| irq | output | 1 | Combined masked interrupt |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_cs_n | output | 1 | Active-low frame select |

## Verification
An edge counter that is off shows up within one frame, as a wrong number of captured bits or a select that rises early. A phase or polarity error corrupts the first frame checked by the bench's independent slave monitor. A queue pointer or level error is seen at the next status read, or when the eighth and ninth words are read back. A divider error changes the measured half period on the first toggle pair. A stuck overrun flag or a wrong interrupt mask is visible at the event register and the irq pin in the cycle after the causing frame.

// File: rtl/spi_fm_pkg.sv
package spi_fm_pkg;
  localparam int DW = 16;
  localparam int NW = $clog2(DW) + 1;
  localparam logic [4:0] OFS_FMT  = 5'h00;
  localparam logic [4:0] OFS_CTL  = 5'h04;
  localparam logic [4:0] OFS_DATA = 5'h08;
  localparam logic [4:0] OFS_STAT = 5'h0C;
  localparam logic [4:0] OFS_PRE  = 5'h10;
  localparam logic [4:0] OFS_EVT  = 5'h14;

  // width code -> bits per frame, codes below 3 clamp to 4 bits
  function automatic logic [NW-1:0] frame_bits(input logic [3:0] code);
    if (code < 4'd3) return NW'(4);
    return NW'(code) + NW'(1);
  endfunction

  function automatic logic [DW-1:0] width_mask(input logic [NW-1:0] nb);
    return DW'((32'h1 << nb) - 32'h1);
  endfunction

  // system clocks per serial half period
  function automatic logic [15:0] half_cycles(input logic [7:0] pre, input logic [7:0] rate);
    logic [15:0] p;
    p = {9'b0, pre[7:1]};
    if (p == 16'd0) p = 16'd1;
    return 16'(p * ({8'b0, rate} + 16'd1));
  endfunction
endpackage

// File: rtl/spi_fm_fifo.sv
module spi_fm_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [$clog2(DEPTH):0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = $clog2(DEPTH);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic push_ok, pop_ok;

  assign full    = (int'(count) == DEPTH);
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rp];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (int'(p) == DEPTH-1) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) if (push_ok) mem[wp] <= wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      if (push_ok && !pop_ok)      count <= count + 1'b1;
      else if (pop_ok && !push_ok) count <= count - 1'b1;
    end
  end

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(count) <= DEPTH);
  assert_fifo_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(count));
endmodule

// File: rtl/spi_fm_clkgen.sv
module spi_fm_clkgen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic [15:0] half,
  output logic        tick
);
  logic [15:0] cnt;
  logic at_end;
  assign at_end = (cnt >= half - 16'd1);
  assign tick   = run && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || at_end) cnt <= '0;
    else                 cnt <= cnt + 16'd1;
  end

  assert_tick_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && half > 16'd1 && $stable(half)) |=> !tick);
endmodule

// File: rtl/spi_fm_engine.sv
module spi_fm_engine #(
  parameter int DW = 16,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          pol,
  input  logic          pha,
  input  logic          loop_en,
  input  logic [NW-1:0] nbits,
  input  logic          tx_avail,
  input  logic [DW-1:0] tx_word,
  input  logic          miso,
  input  logic          tick,
  output logic          tx_pop,
  output logic          rx_push,
  output logic [DW-1:0] rx_word,
  output logic          active,
  output logic          sclk,
  output logic          mosi,
  output logic          cs_n
);
  localparam int CW = $clog2(2*DW) + 1;
  logic [CW-1:0] edge_cnt;
  logic [NW-1:0] nb_q;
  logic [DW-1:0] tx_sr, rx_sr, rx_next;
  logic is_lead, samp, drv, last_edge, sin;

  assign sin       = loop_en ? tx_sr[DW-1] : miso;
  assign is_lead   = ~edge_cnt[0];
  assign samp      = active && tick && (is_lead ^ pha);
  assign drv       = active && tick && !(is_lead ^ pha) && !(pha && edge_cnt == '0);
  assign last_edge = active && tick && (edge_cnt == CW'(2*int'(nb_q) - 1));
  assign tx_pop    = en && !active && tx_avail;
  assign rx_push   = last_edge;
  assign rx_next   = samp ? {rx_sr[DW-2:0], sin} : rx_sr;
  assign rx_word   = rx_next & spi_fm_pkg::width_mask(nb_q);
  assign mosi      = tx_sr[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; cs_n <= 1'b1; sclk <= 1'b0; edge_cnt <= '0;
      nb_q <= NW'(4); tx_sr <= '0; rx_sr <= '0;
    end else if (!en) begin
      active <= 1'b0; cs_n <= 1'b1; sclk <= pol;
    end else if (tx_pop) begin
      active <= 1'b1; cs_n <= 1'b0; sclk <= pol; edge_cnt <= '0;
      nb_q <= nbits; rx_sr <= '0;
      tx_sr <= tx_word << (DW - int'(nbits));
    end else if (active && tick) begin
      sclk     <= ~sclk;
      edge_cnt <= edge_cnt + CW'(1);
      rx_sr    <= rx_next;
      if (drv) tx_sr <= tx_sr << 1;
      if (last_edge) begin
        active <= 1'b0; cs_n <= 1'b1;
      end
    end else if (!active) begin
      sclk <= pol;
    end
  end

  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $stable(pol)) |-> sclk == pol);
  assert_frame_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs_n) && $past(en)) |-> $past(edge_cnt) == CW'(2*int'($past(nb_q)) - 1));
  assert_halt_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> cs_n);
endmodule

// File: rtl/spi_fifo_master.sv
module spi_fifo_master #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        irq,
  output logic        spi_sclk,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_cs_n
);
  import spi_fm_pkg::*;
  localparam int CNTW = $clog2(DEPTH) + 1;

  logic [15:0] fmt_q;
  logic [6:0]  ctl_q;
  logic [7:0]  pre_q;
  logic        ovr_q;
  logic [NW-1:0] nbits;
  logic [DW-1:0] tx_rdata, rx_rdata, rx_word;
  logic [CNTW-1:0] tx_cnt, rx_cnt;
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_push, tx_pop, rx_push, rx_pop, active, tick, busy;
  logic [2:0] evt;

  assign nbits   = frame_bits(fmt_q[3:0]);
  assign tx_push = bus_wr && bus_addr == OFS_DATA;
  assign rx_pop  = bus_rd && bus_addr == OFS_DATA;
  assign busy    = active || !tx_empty;
  assign evt     = {ovr_q, int'(tx_cnt) <= DEPTH/2, int'(rx_cnt) >= DEPTH/2};
  assign irq     = |(evt & ctl_q[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fmt_q <= '0; ctl_q <= '0; pre_q <= '0; ovr_q <= 1'b0;
    end else begin
      if (bus_wr && bus_addr == OFS_FMT) fmt_q <= bus_wdata;
      if (bus_wr && bus_addr == OFS_CTL) ctl_q <= bus_wdata[6:0];
      if (bus_wr && bus_addr == OFS_PRE) pre_q <= bus_wdata[7:0];
      if (rx_push && rx_full)            ovr_q <= 1'b1;
      else if (bus_wr && bus_addr == OFS_EVT) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_FMT:  bus_rdata = fmt_q;
      OFS_CTL:  bus_rdata = {9'b0, ctl_q};
      OFS_DATA: bus_rdata = rx_empty ? 16'h0 : rx_rdata;
      OFS_STAT: bus_rdata = {11'b0, busy, rx_full, !rx_empty, !tx_full, tx_empty};
      OFS_PRE:  bus_rdata = {8'b0, pre_q};
      OFS_EVT:  bus_rdata = {13'b0, evt};
      default:  bus_rdata = 16'h0;
    endcase
  end

  spi_fm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(bus_wdata & width_mask(nbits)),
    .pop(tx_pop), .rdata(tx_rdata), .count(tx_cnt), .full(tx_full), .empty(tx_empty));

  spi_fm_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word),
    .pop(rx_pop), .rdata(rx_rdata), .count(rx_cnt), .full(rx_full), .empty(rx_empty));

  spi_fm_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(active), .half(half_cycles(pre_q, fmt_q[15:8])), .tick(tick));

  spi_fm_engine #(.DW(DW), .NW(NW)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(ctl_q[4]), .pol(fmt_q[6]), .pha(fmt_q[7]),
    .loop_en(ctl_q[3]), .nbits(nbits), .tx_avail(!tx_empty), .tx_word(tx_rdata),
    .miso(spi_miso), .tick(tick), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
    .active(active), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n));

  assert_ovr_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> ovr_q);
  assert_empty_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pop && rx_empty && !rx_push) |=> rx_cnt == '0);
  assert_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> busy);
endmodule

// File: tb/spi_fifo_master_tb.sv
module spi_fifo_master_tb;
  logic clk = 0, rst_n = 0;
  logic [4:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0, spi_miso = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic irq, spi_sclk, spi_mosi, spi_cs_n;
  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic cur_pol = 0, cur_pha = 0;
  logic [15:0] cap = 0, last_frame = 0;
  int cap_n = 0, last_n = 0, last_tog = 0, half_meas = 0;
  logic prev_sclk = 0, prev_cs = 1;

  always #10 clk = ~clk;
  always @(posedge clk) cyc++;

  spi_fifo_master u_dut (.*);

  // independent slave monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (spi_sclk !== prev_sclk) begin
        half_meas = cyc - last_tog; last_tog = cyc;
        if (!prev_cs && ((spi_sclk != cur_pol) != cur_pha)) begin
          cap = {cap[14:0], spi_mosi}; cap_n++;
        end
      end
      if (spi_cs_n && !prev_cs) begin last_frame = cap; last_n = cap_n; end
      if (!spi_cs_n && prev_cs) begin cap = 0; cap_n = 0; end
    end
    prev_sclk = spi_sclk; prev_cs = spi_cs_n;
  end

  function automatic int bits_of(input int code);
    return (code < 3) ? 4 : code + 1;
  endfunction
  function automatic logic [15:0] msk(input int nb);
    return 16'((32'h1 << nb) - 1);
  endfunction
  function automatic int half_of(input int pre, input int rate);
    int p = pre / 2;
    if (p == 0) p = 1;
    return p * (rate + 1);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1 bus_wr = 0;
  endtask
  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1; #2 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 0;
  endtask
  task automatic wait_idle();
    logic [15:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(5'h0C, s);
      if (!s[4]) break;
    end
  endtask
  task automatic set_fmt(input int code, input int pol, input int pha, input int rate);
    cur_pol = 1'(pol); cur_pha = 1'(pha);
    wr(5'h00, {8'(rate), 1'(pha), 1'(pol), 2'b0, 4'(code)});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    int w, d, code;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 cs_n", spi_cs_n, 1); check("R1 sclk", spi_sclk, 0); check("R1 irq", irq, 0);
    rd(5'h0C, r); check("R1 status", r, 16'h03);
    rd(5'h14, r); check("R1 events", r, 16'h02);

    // R2 register readback
    set_fmt(7, 0, 0, 0); wr(5'h10, 16'h0002); wr(5'h04, 16'h0018);
    rd(5'h00, r); check("R2 fmt", r, 16'h0007);
    rd(5'h10, r); check("R2 pre", r, 16'h0002);
    rd(5'h04, r); check("R2 ctl", r, 16'h0018);

    // R6 loopback ignores miso
    spi_miso = 1; wr(5'h08, 16'h005A); wait_idle();
    rd(5'h08, r); check("R6 loopback data", r, 16'h5A);
    check("R3 mosi frame", last_frame & 16'hFF, 16'h5A);
    // R6 external input
    wr(5'h04, 16'h0010); wr(5'h08, 16'h0033); wait_idle();
    rd(5'h08, r); check("R6 miso ones", r, 16'hFF);
    spi_miso = 0; wr(5'h08, 16'h00C3); wait_idle();
    rd(5'h08, r); check("R6 miso zeros", r, 16'h00);
    check("R3 mosi no loop", last_frame & 16'hFF, 16'hC3);

    // R3 small code clamps to 4 bits
    wr(5'h04, 16'h0018); set_fmt(1, 0, 0, 0); wr(5'h08, 16'hFFFF); wait_idle();
    check("R3 clamp bits", last_n, 4);
    rd(5'h08, r); check("R3 clamp data", r, 16'h000F);

    // R5 divider and R4 idle level
    set_fmt(7, 1, 0, 2); wr(5'h10, 16'h0006); wr(5'h08, 16'h0081); wait_idle();
    check("R5 half period", half_meas, half_of(6, 2));
    check("R4 idle high", spi_sclk, 1);
    rd(5'h08, r); check("R4 pol data", r, 16'h81);
    set_fmt(7, 0, 1, 3); wr(5'h10, 16'h0000); wr(5'h08, 16'h0042); wait_idle();
    check("R5 prescale floor", half_meas, half_of(0, 3));
    rd(5'h08, r); check("R4 pha data", r, 16'h42);
    wr(5'h10, 16'h0002); set_fmt(7, 0, 0, 0);

    // R10 / R7 / R11 halted with full queue
    wr(5'h04, 16'h0008);
    for (int i = 0; i < 9; i++) wr(5'h08, 16'(16'h10 + i));
    rd(5'h0C, r); check("R7 R11 tx full status", r, 16'h10);
    repeat (20) @(posedge clk); #1;
    check("R10 cs held", spi_cs_n, 1);
    wr(5'h04, 16'h0018); wait_idle();
    rd(5'h0C, r); check("R7 rx full status", r, 16'h0F);
    rd(5'h14, r); check("R9 events full", r, 16'h03);
    // R8 overrun
    wr(5'h08, 16'h00AB); wait_idle();
    rd(5'h14, r); check("R8 overrun flag", r, 16'h07);
    wr(5'h04, 16'h001C); @(negedge clk); check("R9 ovr irq", irq, 1);
    wr(5'h14, 16'h0000); @(negedge clk); check("R8 cleared irq", irq, 0);
    rd(5'h14, r); check("R8 cleared flag", r, 16'h03);
    for (int i = 0; i < 8; i++) begin
      rd(5'h08, r); check("R7 R8 rx order", r, 16'h10 + i);
    end
    rd(5'h08, r); check("R12 empty read", r, 0);
    rd(5'h0C, r); check("R12 status after", r, 16'h03);

    // R9 thresholds
    wr(5'h04, 16'h0019);
    for (int i = 0; i < 3; i++) wr(5'h08, 16'(i));
    wait_idle(); @(negedge clk); check("R9 rx below", irq, 0);
    wr(5'h08, 16'h0003); wait_idle(); @(negedge clk); check("R9 rx at half", irq, 1);
    for (int i = 0; i < 4; i++) rd(5'h08, r);
    wr(5'h04, 16'h001A); @(negedge clk); check("R9 tx low", irq, 1);
    wr(5'h04, 16'h0018);

    // random frames, loopback
    for (int n = 0; n < 40; n++) begin
      code = $urandom_range(15, 3); w = bits_of(code);
      d = $urandom_range(16'hFFFF, 0);
      set_fmt(code, $urandom_range(1, 0), $urandom_range(1, 0), $urandom_range(1, 0));
      wr(5'h08, 16'(d)); wait_idle();
      check("R3 random bits", last_n, w);
      check("R4 random mosi", last_frame & msk(w), d & msk(w));
      rd(5'h08, r); check("R6 random rx", r, d & msk(w));
    end
    finish_run();
  end
endmodule